// File: doc/BRIEF.md
# Glitch-Free Clock Stop and Power-Down Controller

This block sits between the clock dividers of a clock generator and its output drivers. Its inputs are a set of single-ended source clocks, several differential CPU clock pairs and one differential serial-reference pair. It passes each source through a gate and shuts the outputs down when an active-low power-down request arrives. It also stops a chosen subset of outputs when a bus-clock stop request is raised. Every source clock is a level signal that is registered on the block's master clock `clk`. Gating decisions are taken on that clock, so an output can change state only on an edge of its own source.

Per-output configuration bits set the behaviour. An enable bit turns an output on. A stop-enable bit makes the output follow the stop request. A park-mode bit on each differential pair selects what the pair does in power-down. In power-down a single-ended output freezes low once its current high phase has ended. A differential pair either parks with its true side driven high and its complement undriven, or releases both sides to three-state. The per-output drive-enable outputs model the three-state condition. When the power-down request is withdrawn, a programmable wake delay runs before the clocks return. Every single-ended output then restarts with a full-width pulse.

Top module: `clkgate_pd_ctrl`

## Requirements
- R1: Power-down is entered only after the synchronized `pd_n` has been sampled low at two consecutive rising edges of `cpu_c_src[0]`. A single low sample, followed by a high sample at the next such edge, has no effect.
- R2: When power-down is entered, each enabled single-ended output ends its current high phase with its source and then stays low for as long as power-down lasts.
- R3: A single-ended output is never high while its source is low, and every high pulse it emits lasts exactly one full high phase of its source.
- R4: In power-down, a CPU pair whose park-mode bit is 0 drives its true output high (`cpu_t_oe`=1, `cpu_t_out`=1) and leaves its complement undriven (`cpu_c_oe`=0). The serial-reference pair behaves the same way when `srp_pd_tri`=0.
- R5: In power-down, a CPU pair whose `cpu_pd_tri` bit is 1 has both drive enables at 0. The serial-reference pair does the same when `srp_pd_tri`=1.
- R6: While `stop_req` is high (after synchronization), single-ended outputs with `se_stop_en`=1 freeze low and those with 0 keep following their source. The serial-reference pair, if `srp_stop_en`=1, parks with its true output high and its complement undriven.
- R7: An enable bit of 0 holds a single-ended output low, and removes both drive enables of a differential pair, in any power state.
- R8: After `pd_n` returns high, all outputs stay parked for at least `WAKE_CYCLES` cycles and are then released. Each single-ended output restarts at a rising edge of its source.
- R9: During reset all single-ended outputs are low and the differential pairs pass their sources, with drive enables equal to their enable bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock on which sources are registered |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_n | input | 1 | Asynchronous active-low power-down request |
| stop_req | input | 1 | Asynchronous active-high bus-clock stop request |
| se_src | input | N_SE | Single-ended source clocks |
| cpu_t_src | input | N_CPU | CPU pair true source clocks |
| cpu_c_src | input | N_CPU | CPU pair complement source clocks |
| srp_t_src | input | 1 | Serial-reference pair true source |
| srp_c_src | input | 1 | Serial-reference pair complement source |
| se_en | input | N_SE | Single-ended output enables |
| se_stop_en | input | N_SE | Single-ended stop-enable bits |
| cpu_en | input | N_CPU | CPU pair enables |
| cpu_pd_tri | input | N_CPU | CPU pair park mode: 1 = three-state in power-down |
| srp_en | input | 1 | Serial-reference pair enable |
| srp_stop_en | input | 1 | Serial-reference pair stop-enable bit |
| srp_pd_tri | input | 1 | Serial-reference pair park mode |
| se_out | output | N_SE | Gated single-ended clocks |
| cpu_t_out | output | N_CPU | CPU pair true outputs |
| cpu_c_out | output | N_CPU | CPU pair complement outputs |
| cpu_t_oe | output | N_CPU | CPU pair true drive enables |
| cpu_c_oe | output | N_CPU | CPU pair complement drive enables |
| srp_t_out | output | 1 | Serial-reference true output |
| srp_c_out | output | 1 | Serial-reference complement output |
| srp_t_oe | output | 1 | Serial-reference true drive enable |
| srp_c_oe | output | 1 | Serial-reference complement drive enable |

## Verification
The bench builds the block with four single-ended outputs and two CPU pairs. The single-ended sources have high phases of one to four master cycles, so one run covers both the fastest possible source and slower ones. That lets a stop or power-down request land in every phase of a source. The CPU pairs have a four-cycle period, which makes it possible to fit a `pd_n` pulse around exactly one complement rising edge. A wake delay of 40 cycles keeps the restart window short enough to check cycle by cycle while remaining clearly longer than the synchronizer latency.

// File: rtl/clkgate_pkg.sv
package clkgate_pkg;
  typedef enum logic [1:0] {
    PWR_RUN  = 2'd0,
    PWR_PARK = 2'd1,
    PWR_WAKE = 2'd2
  } pwr_state_e;
endpackage

// File: rtl/cg_sync.sv
module cg_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] rst_val,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= rst_val;
      q      <= rst_val;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/cg_pd_seq.sv
module cg_pd_seq
  import clkgate_pkg::*;
#(
  parameter int WAKE_CYCLES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pd_n_s,
  input  logic cpuc_src,
  output logic pd_hold
);
  localparam int CW = (WAKE_CYCLES > 1) ? $clog2(WAKE_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(WAKE_CYCLES - 1);

  pwr_state_e    state_q, state_d;
  logic          seen_q, seen_d;
  logic          cpuc_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cpuc_rise;

  assign cpuc_rise = cpuc_src & ~cpuc_q;

  always_comb begin
    state_d = state_q;
    seen_d  = seen_q;
    cnt_d   = cnt_q;
    case (state_q)
      PWR_RUN: begin
        if (cpuc_rise) begin
          if (!pd_n_s) begin
            if (seen_q) begin
              state_d = PWR_PARK;
              seen_d  = 1'b0;
            end else begin
              seen_d = 1'b1;
            end
          end else begin
            seen_d = 1'b0;
          end
        end
      end
      PWR_PARK: begin
        if (pd_n_s) begin
          state_d = PWR_WAKE;
          cnt_d   = '0;
        end
      end
      PWR_WAKE: begin
        if (!pd_n_s) begin
          state_d = PWR_PARK;
        end else if (cnt_q == LAST) begin
          state_d = PWR_RUN;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: state_d = PWR_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PWR_RUN;
      seen_q  <= 1'b0;
      cpuc_q  <= 1'b0;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      seen_q  <= seen_d;
      cpuc_q  <= cpuc_src;
      cnt_q   <= cnt_d;
    end
  end

  assign pd_hold = (state_q != PWR_RUN);
endmodule

// File: rtl/cg_se_gate.sv
module cg_se_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic src,
  input  logic want,
  output logic out
);
  logic en_q, en_d, en_ce;

  // the enable may only move while the source sits low
  assign en_ce = ~src;
  assign en_d  = want;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= 1'b0;
    else if (en_ce) en_q <= en_d;
  end

  assign out = src & en_q;
endmodule

// File: rtl/cg_diff_park.sv
module cg_diff_park (
  input  logic clk,
  input  logic rst_n,
  input  logic t_src,
  input  logic c_src,
  input  logic en,
  input  logic park_want,
  input  logic tri_want,
  output logic t_out,
  output logic c_out,
  output logic t_oe,
  output logic c_oe
);
  logic park_q, tri_q, park_ce;

  // park state moves while true side is high: true stays high, complement is already low
  assign park_ce = t_src;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      park_q <= 1'b0;
      tri_q  <= 1'b0;
    end else if (park_ce) begin
      park_q <= park_want;
      tri_q  <= tri_want;
    end
  end

  assign t_out = park_q ? 1'b1 : t_src;
  assign c_out = park_q ? 1'b0 : c_src;
  assign t_oe  = en & ~(park_q & tri_q);
  assign c_oe  = en & ~park_q;
endmodule

// File: rtl/clkgate_pd_ctrl.sv
module clkgate_pd_ctrl #(
  parameter int N_SE        = 4,
  parameter int N_CPU       = 2,
  parameter int WAKE_CYCLES = 1000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pd_n,
  input  logic             stop_req,
  input  logic [N_SE-1:0]  se_src,
  input  logic [N_CPU-1:0] cpu_t_src,
  input  logic [N_CPU-1:0] cpu_c_src,
  input  logic             srp_t_src,
  input  logic             srp_c_src,
  input  logic [N_SE-1:0]  se_en,
  input  logic [N_SE-1:0]  se_stop_en,
  input  logic [N_CPU-1:0] cpu_en,
  input  logic [N_CPU-1:0] cpu_pd_tri,
  input  logic             srp_en,
  input  logic             srp_stop_en,
  input  logic             srp_pd_tri,
  output logic [N_SE-1:0]  se_out,
  output logic [N_CPU-1:0] cpu_t_out,
  output logic [N_CPU-1:0] cpu_c_out,
  output logic [N_CPU-1:0] cpu_t_oe,
  output logic [N_CPU-1:0] cpu_c_oe,
  output logic             srp_t_out,
  output logic             srp_c_out,
  output logic             srp_t_oe,
  output logic             srp_c_oe
);
  logic [1:0] req_s;
  logic       pd_n_s, stop_s, pd_hold;

  cg_sync #(.W(2)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_val (2'b01),
    .d       ({stop_req, pd_n}),
    .q       (req_s)
  );
  assign pd_n_s = req_s[0];
  assign stop_s = req_s[1];

  cg_pd_seq #(.WAKE_CYCLES(WAKE_CYCLES)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .pd_n_s   (pd_n_s),
    .cpuc_src (cpu_c_src[0]),
    .pd_hold  (pd_hold)
  );

  for (genvar i = 0; i < N_SE; i++) begin : g_se
    logic want;
    assign want = se_en[i] & ~pd_hold & ~(stop_s & se_stop_en[i]);
    cg_se_gate u_gate (
      .clk   (clk),
      .rst_n (rst_n),
      .src   (se_src[i]),
      .want  (want),
      .out   (se_out[i])
    );
  end

  for (genvar p = 0; p < N_CPU; p++) begin : g_cpu
    cg_diff_park u_pair (
      .clk       (clk),
      .rst_n     (rst_n),
      .t_src     (cpu_t_src[p]),
      .c_src     (cpu_c_src[p]),
      .en        (cpu_en[p]),
      .park_want (pd_hold),
      .tri_want  (pd_hold & cpu_pd_tri[p]),
      .t_out     (cpu_t_out[p]),
      .c_out     (cpu_c_out[p]),
      .t_oe      (cpu_t_oe[p]),
      .c_oe      (cpu_c_oe[p])
    );
  end

  cg_diff_park u_srp (
    .clk       (clk),
    .rst_n     (rst_n),
    .t_src     (srp_t_src),
    .c_src     (srp_c_src),
    .en        (srp_en),
    .park_want (pd_hold | (stop_s & srp_stop_en)),
    .tri_want  (pd_hold & srp_pd_tri),
    .t_out     (srp_t_out),
    .c_out     (srp_c_out),
    .t_oe      (srp_t_oe),
    .c_oe      (srp_c_oe)
  );
endmodule

// File: rtl/cg_checker.sv
module cg_checker #(
  parameter int N_SE  = 4,
  parameter int N_CPU = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_SE-1:0]  se_src,
  input logic [N_SE-1:0]  se_out,
  input logic [N_CPU-1:0] cpu_en,
  input logic [N_CPU-1:0] cpu_t_out,
  input logic [N_CPU-1:0] cpu_t_oe,
  input logic [N_CPU-1:0] cpu_c_oe,
  input logic             srp_t_out,
  input logic             srp_t_oe,
  input logic             srp_c_oe
);
  assert_out_within_src_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (se_out & ~se_src) == '0);

  for (genvar i = 0; i < N_SE; i++) begin : g_se_chk
    assert_fall_with_src_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(se_out[i]) |-> $fell(se_src[i]));
    assert_rise_with_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(se_out[i]) |-> $rose(se_src[i]));
  end

  for (genvar p = 0; p < N_CPU; p++) begin : g_cpu_chk
    assert_disabled_pair_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_en[p] |-> (!cpu_t_oe[p] && !cpu_c_oe[p]));
    assert_parked_true_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_t_oe[p] && !cpu_c_oe[p]) |-> cpu_t_out[p]);
  end

  assert_srp_parked_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (srp_t_oe && !srp_c_oe) |-> srp_t_out);
endmodule

bind clkgate_pd_ctrl cg_checker #(.N_SE(N_SE), .N_CPU(N_CPU)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .se_src    (se_src),
  .se_out    (se_out),
  .cpu_en    (cpu_en),
  .cpu_t_out (cpu_t_out),
  .cpu_t_oe  (cpu_t_oe),
  .cpu_c_oe  (cpu_c_oe),
  .srp_t_out (srp_t_out),
  .srp_t_oe  (srp_t_oe),
  .srp_c_oe  (srp_c_oe)
);

// File: tb/clkgate_pd_ctrl_bench.sv
`timescale 1ns/1ps
module clkgate_pd_ctrl_bench;
  localparam int N_SE  = 4;
  localparam int N_CPU = 2;
  localparam int WAKE  = 40;

  logic clk = 1'b0;
  logic rst_n, pd_n, stop_req;
  logic [N_SE-1:0]  se_src, se_en, se_stop_en, se_out;
  logic [N_CPU-1:0] cpu_t_src, cpu_c_src, cpu_en, cpu_pd_tri;
  logic [N_CPU-1:0] cpu_t_out, cpu_c_out, cpu_t_oe, cpu_c_oe;
  logic srp_t_src, srp_c_src, srp_en, srp_stop_en, srp_pd_tri;
  logic srp_t_out, srp_c_out, srp_t_oe, srp_c_oe;

  int n_checks = 0;
  int n_fail   = 0;
  bit mon_on   = 1'b0;
  bit done     = 1'b0;

  always #4 clk = ~clk;

  clkgate_pd_ctrl #(.N_SE(N_SE), .N_CPU(N_CPU), .WAKE_CYCLES(WAKE)) u_clkgate_pd_ctrl (
    .clk(clk), .rst_n(rst_n), .pd_n(pd_n), .stop_req(stop_req),
    .se_src(se_src), .cpu_t_src(cpu_t_src), .cpu_c_src(cpu_c_src),
    .srp_t_src(srp_t_src), .srp_c_src(srp_c_src),
    .se_en(se_en), .se_stop_en(se_stop_en), .cpu_en(cpu_en), .cpu_pd_tri(cpu_pd_tri),
    .srp_en(srp_en), .srp_stop_en(srp_stop_en), .srp_pd_tri(srp_pd_tri),
    .se_out(se_out), .cpu_t_out(cpu_t_out), .cpu_c_out(cpu_c_out),
    .cpu_t_oe(cpu_t_oe), .cpu_c_oe(cpu_c_oe),
    .srp_t_out(srp_t_out), .srp_c_out(srp_c_out), .srp_t_oe(srp_t_oe), .srp_c_oe(srp_c_oe)
  );

  function automatic int se_half(input int i);
    return i + 1;
  endfunction

  function automatic logic [N_SE-1:0] follow_mask(input logic [N_SE-1:0] en,
                                                  input logic [N_SE-1:0] sten,
                                                  input logic stop);
    return en & ~(sten & {N_SE{stop}});
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  // source clocks: registered on clk like an upstream divider
  initial begin
    int se_div[N_SE];
    int cpu_div, srp_div;
    se_src = '0; cpu_t_src = '0; cpu_c_src = '1; srp_t_src = 1'b0; srp_c_src = 1'b1;
    cpu_div = 0; srp_div = 0;
    for (int i = 0; i < N_SE; i++) se_div[i] = 0;
    forever begin
      @(posedge clk);
      for (int i = 0; i < N_SE; i++) begin
        if (se_div[i] == se_half(i) - 1) begin
          se_div[i] = 0;
          se_src[i] <= ~se_src[i];
        end else se_div[i] = se_div[i] + 1;
      end
      if (cpu_div == 1) begin
        cpu_div = 0;
        cpu_t_src <= ~cpu_t_src;
        cpu_c_src <= cpu_t_src;
      end else cpu_div = cpu_div + 1;
      if (srp_div == 2) begin
        srp_div = 0;
        srp_t_src <= ~srp_t_src;
        srp_c_src <= srp_t_src;
      end else srp_div = srp_div + 1;
    end
  end

  // pulse monitor: every high pulse must sit inside and span a source high phase
  initial begin
    int hi_cnt[N_SE];
    logic [N_SE-1:0] prev;
    prev = '0;
    for (int i = 0; i < N_SE; i++) hi_cnt[i] = 0;
    forever begin
      @(negedge clk);
      if (mon_on) begin
        for (int i = 0; i < N_SE; i++) begin
          if (se_out[i] && !se_src[i]) chk(1'b0, "R3 high without source", i, 0);
          if (se_out[i]) hi_cnt[i]++;
          else if (prev[i]) begin
            chk(hi_cnt[i] == se_half(i), "R3 pulse width", hi_cnt[i], se_half(i));
            hi_cnt[i] = 0;
          end
        end
      end
      prev = se_out;
    end
  end

  // count cycles where masked outputs differ from their sources or unmasked ones are high
  task automatic window(input int n, input logic [N_SE-1:0] fmask, output int bad);
    bad = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if ((se_out & fmask) != (se_src & fmask)) bad++;
      if ((se_out & ~fmask) != '0) bad++;
    end
  endtask

  initial begin
    #(8ns * 190000);
    if (!done) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int bad;
    bit seen_rise, any_off;
    void'($urandom(32'd2024));
    rst_n = 1'b0; pd_n = 1'b1; stop_req = 1'b0;
    se_en = '1; se_stop_en = 4'b0101; cpu_en = '1; cpu_pd_tri = 2'b10;
    srp_en = 1'b1; srp_stop_en = 1'b1; srp_pd_tri = 1'b0;
    cycles(4);
    // R9: reset state
    chk(se_out == '0, "R9 se_out in reset", se_out, 0);
    chk(cpu_t_oe == '1 && cpu_c_oe == '1, "R9 pair drive in reset", {cpu_t_oe, cpu_c_oe}, 4'hF);
    chk(cpu_t_out == cpu_t_src, "R9 pair follows in reset", cpu_t_out, cpu_t_src);
    @(posedge clk); rst_n <= 1'b1; mon_on = 1'b1;
    cycles(10);
    window(24, '1, bad);
    chk(bad == 0, "R3 outputs follow sources", bad, 0);

    // R7: disable one single-ended output and one pair
    @(posedge clk); se_en[3] <= 1'b0; cpu_en[1] <= 1'b0;
    cycles(12);
    window(20, 4'b0111, bad);
    chk(bad == 0, "R7 disabled output held low", bad, 0);
    chk(cpu_t_oe[1] == 0 && cpu_c_oe[1] == 0, "R7 disabled pair undriven", {cpu_t_oe[1], cpu_c_oe[1]}, 0);
    @(posedge clk); se_en[3] <= 1'b1; cpu_en[1] <= 1'b1;
    cycles(12);

    // R6: stop request
    @(posedge clk); stop_req <= 1'b1;
    cycles(14);
    window(20, follow_mask(se_en, se_stop_en, 1'b1), bad);
    chk(bad == 0, "R6 stop-enabled outputs frozen", bad, 0);
    chk(srp_t_oe && !srp_c_oe && srp_t_out, "R6 serial pair parked on stop",
        {srp_t_oe, srp_c_oe, srp_t_out}, 3'b101);
    @(posedge clk); stop_req <= 1'b0;
    cycles(14);
    window(20, '1, bad);
    chk(bad == 0, "R6 outputs resume after stop", bad, 0);

    // R1: one low sample must be ignored (pulse spans one complement rise)
    @(posedge clk); pd_n <= 1'b0;
    repeat (4) @(posedge clk);
    pd_n <= 1'b1;
    any_off = 1'b0;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      if (cpu_c_oe != '1) any_off = 1'b1;
    end
    chk(!any_off, "R1 single sample ignored", any_off, 0);

    // R2 R4 R5: full power-down
    @(posedge clk); pd_n <= 1'b0;
    cycles(30);
    window(20, '0, bad);
    chk(bad == 0, "R2 outputs frozen low in power-down", bad, 0);
    chk(cpu_t_oe[0] && !cpu_c_oe[0] && cpu_t_out[0], "R4 pair0 parked true high",
        {cpu_t_oe[0], cpu_c_oe[0], cpu_t_out[0]}, 3'b101);
    chk(srp_t_oe && !srp_c_oe && srp_t_out, "R4 serial pair parked",
        {srp_t_oe, srp_c_oe, srp_t_out}, 3'b101);
    chk(!cpu_t_oe[1] && !cpu_c_oe[1], "R5 pair1 three-state", {cpu_t_oe[1], cpu_c_oe[1]}, 0);
    @(posedge clk); srp_pd_tri <= 1'b1;
    cycles(8);
    chk(!srp_t_oe && !srp_c_oe, "R5 serial pair three-state", {srp_t_oe, srp_c_oe}, 0);
    @(posedge clk); cpu_en[0] <= 1'b0;
    cycles(2);
    chk(!cpu_t_oe[0] && !cpu_c_oe[0], "R7 disable wins in power-down", {cpu_t_oe[0], cpu_c_oe[0]}, 0);
    @(posedge clk); cpu_en[0] <= 1'b1; srp_pd_tri <= 1'b0;

    // R8: wake delay
    @(posedge clk); pd_n <= 1'b1;
    any_off = 1'b0;
    for (int k = 0; k < WAKE; k++) begin
      @(negedge clk);
      if (se_out != '0 || cpu_c_oe[0]) any_off = 1'b1;
    end
    chk(!any_off, "R8 parked through wake delay", any_off, 0);
    seen_rise = 1'b0;
    for (int k = 0; k < 24; k++) begin
      @(negedge clk);
      if (se_out[0]) seen_rise = 1'b1;
    end
    chk(seen_rise, "R8 clocks restart after delay", seen_rise, 1);
    chk(cpu_c_oe == '1, "R8 pairs released", cpu_c_oe, 3);

    // random phase: pulse monitor keeps checking R3 throughout
    for (int r = 0; r < 300; r++) begin
      @(posedge clk);
      stop_req   <= $urandom_range(0, 1);
      se_en      <= N_SE'($urandom);
      se_stop_en <= N_SE'($urandom);
      if ($urandom_range(0, 7) == 0) pd_n <= ~pd_n;
      repeat ($urandom_range(3, 20)) @(posedge clk);
    end
    @(posedge clk); pd_n <= 1'b1; stop_req <= 1'b0; se_en <= '1;
    cycles(WAKE + 30);
    window(24, '1, bad);
    chk(bad == 0, "R3 follow after random phase", bad, 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule